// File: doc/BRIEF.md
# Double-Buffered Byte-Loaded Converter Code Register

This block is the digital front end of a 16-bit digital-to-analog converter whose host has only an 8-bit data bus. The host writes the word in two bytes into a pair of input latches. A separate transfer step then copies the assembled word into an output register. That output register holds the code the converter sees. Because of this double buffering, a new word can be staged while the converter keeps showing the previous one.

All controls are active low except the byte-sequence select. Chip select gates write 1. Write 2 gates transfer. The byte select decides whether a write fills both latches or only the low one. The logic is fully synchronous to one system clock. A latch follows the bus on every clock while it is enabled and holds its value once the enable drops. The output code is plain unsigned binary: all ones is full scale and all zeros is zero output.

Top module: `dacbuf_core`

## Requirements
- R1: Bus bit i (i = 0..7) lands in code bit i+8 in the high latch and in code bit i in the low latch. The output register presents the word as {high latch, low latch}, unsigned.
- R2: Write 1 acts only when chip select is low (latch enable = !cs_n && !wr1_n). A write 1 strobe while cs_n is high changes neither latch.
- R3: With byte_hi = 1, an enabled write 1 loads the bus into both the high and the low latch.
- R4: With byte_hi = 0, an enabled write 1 loads only the low latch, and the high latch keeps its value.
- R5: An enabled latch takes the bus on every clock while the enable stays active, and holds its last value while the enable is inactive.
- R6: The output register loads {high latch, low latch} on a clock where wr2_n and xfer_n are both low. On every other clock it holds, so a staged word does not reach the output.
- R7: When a latch write and a transfer fall in the same clock, the output register receives the value just written into the latch.
- R8: With xfer_n tied to byte_hi and wr2_n tied to wr1_n, the high-byte write only stages the word. The following low-byte write also transfers the full 16-bit word on that same clock.
- R9: A clock with rst_n low clears both latches and the output register to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_n | input | 1 | Chip select, active low; gates write 1 |
| wr1_n | input | 1 | Input-latch write strobe, active low |
| wr2_n | input | 1 | Transfer gate, active low; enables xfer_n |
| xfer_n | input | 1 | Transfer request, active low |
| byte_hi | input | 1 | 1: write fills both latches; 0: write fills the low latch only |
| bus_in | input | 8 | Byte data bus |
| code | output | 16 | Unsigned code held for the converter |

## Verification
The assertions assume that the strobes and the bus are synchronous levels. Each level is taken as a command on the clock edge where it is sampled, with no setup or pulse-width rule beyond the clock itself. The bench keeps to this by changing every input only on the falling edge, one full cycle per command, and by deriving the auto-transfer pins from byte_hi and wr1_n in the bench. That creates no combinational path at the block's edge. The stimulus covers several cases: the two writes followed by a transfer, a word staged while the old one is held, a strobe without chip select, multi-cycle enables with a changing bus, a write and a transfer on the same clock, and a reset in the middle of a sequence.

// File: rtl/dacbuf_pkg.sv
// Shared types for the byte-loaded converter code register.
// Assumes: one clock domain; all enables are decoded as active-high.
package dacbuf_pkg;

    // Decoded per-clock commands derived from the active-low strobes.
    typedef struct packed {
        logic lat_en;   // a latch write happens this clock
        logic hi_en;    // the high latch is also written
        logic xfer_en;  // output register loads this clock
    } dacbuf_cmd_t;

endpackage

// File: rtl/dacbuf_strobe_dec.sv
// Strobe decoder: turns the active-low host controls into active-high
// commands. Chip select qualifies write 1, and write 2 qualifies transfer.
// Assumes: inputs are already synchronous to the block clock.
module dacbuf_strobe_dec
    import dacbuf_pkg::*;
(
    input  logic        cs_n,
    input  logic        wr1_n,
    input  logic        wr2_n,
    input  logic        xfer_n,
    input  logic        byte_hi,
    output dacbuf_cmd_t cmd
);

    // Combine the strobe pairs into the three commands.
    always_comb begin
        cmd.lat_en  = !cs_n && !wr1_n;
        cmd.hi_en   = !cs_n && !wr1_n && byte_hi;
        cmd.xfer_en = !wr2_n && !xfer_n;
    end

endmodule

// File: rtl/dacbuf_byte_latch.sv
// One input latch slice. It follows din on every clock while en is high
// and holds otherwise. The next-state value is exposed so that a downstream
// register loaded on the same clock sees the fresh data.
// Assumes: synchronous active-low reset.
module dacbuf_byte_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] din,
    output logic [W-1:0] nxt,
    output logic [W-1:0] q
);

    // Select between the held value and the bus.
    always_comb begin
        nxt = en ? din : q;
    end

    // Register the slice with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= nxt;
    end

endmodule

// File: rtl/dacbuf_out_reg.sv
// Output code register: loads the assembled word when load is high and
// holds otherwise.
// Assumes: synchronous active-low reset; din is already the fresh word.
module dacbuf_out_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);

    // Load or hold the converter code.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= din;
    end

endmodule

// File: rtl/dacbuf_core.sv
// Top of the double-buffered byte-loaded code register. Two byte slices
// are built by a generate loop. Slice 0 (low) is written on every enabled
// write; slice 1 (high) only when the byte select is high. The output
// register takes {slice1, slice0} next-state values on transfer.
// Assumes: all inputs synchronous to clk; reset synchronous active low.
module dacbuf_core
    import dacbuf_pkg::*;
#(
    parameter int BUS_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_n,
    input  logic               wr1_n,
    input  logic               wr2_n,
    input  logic               xfer_n,
    input  logic               byte_hi,
    input  logic [BUS_W-1:0]   bus_in,
    output logic [2*BUS_W-1:0] code
);

    localparam int NSLICE = 2;
    localparam int CODE_W = NSLICE * BUS_W;

    dacbuf_cmd_t              cmd;
    logic [NSLICE-1:0]        slice_en;
    logic [BUS_W-1:0]         slice_nxt [NSLICE];
    logic [BUS_W-1:0]         slice_q   [NSLICE];
    logic [BUS_W-1:0]         hi_q;
    logic [BUS_W-1:0]         lo_q;
    logic [CODE_W-1:0]        word_nxt;

    dacbuf_strobe_dec u_dec (
        .cs_n    (cs_n),
        .wr1_n   (wr1_n),
        .wr2_n   (wr2_n),
        .xfer_n  (xfer_n),
        .byte_hi (byte_hi),
        .cmd     (cmd)
    );

    // Per-slice enables: low slice on any write, high slice on a select.
    always_comb begin
        slice_en[0] = cmd.lat_en;
        slice_en[1] = cmd.hi_en;
    end

    for (genvar g = 0; g < NSLICE; g++) begin : g_slice
        dacbuf_byte_latch #(.W(BUS_W)) u_lat (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (slice_en[g]),
            .din   (bus_in),
            .nxt   (slice_nxt[g]),
            .q     (slice_q[g])
        );
    end

    // Assemble the word from fresh slice values; expose held halves.
    always_comb begin
        word_nxt = {slice_nxt[1], slice_nxt[0]};
        hi_q     = slice_q[1];
        lo_q     = slice_q[0];
    end

    dacbuf_out_reg #(.W(CODE_W)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (cmd.xfer_en),
        .din   (word_nxt),
        .q     (code)
    );

endmodule

// File: rtl/dacbuf_core_chk.sv
// Assertion checker for dacbuf_core, attached by bind. It relates the
// strobes to the held latch halves and to the output code.
module dacbuf_core_chk #(
    parameter int BUS_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cs_n,
    input logic               wr1_n,
    input logic               wr2_n,
    input logic               xfer_n,
    input logic               byte_hi,
    input logic [BUS_W-1:0]   bus_in,
    input logic [BUS_W-1:0]   hi_q,
    input logic [BUS_W-1:0]   lo_q,
    input logic [2*BUS_W-1:0] code
);

    AST_NO_CS_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cs_n)) |-> ($stable(hi_q) && $stable(lo_q))); // R2

    AST_BOTH_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(cs_n) && !$past(wr1_n) && $past(byte_hi))
        |-> (hi_q == $past(bus_in) && lo_q == $past(bus_in))); // R3

    AST_LOW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(cs_n) && !$past(wr1_n) && !$past(byte_hi))
        |-> ($stable(hi_q) && lo_q == $past(bus_in))); // R4

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr1_n)) |-> ($stable(hi_q) && $stable(lo_q))); // R5

    AST_XFER_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wr2_n) && !$past(xfer_n))
        |-> (code == {hi_q, lo_q})); // R7

    AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(wr2_n) || $past(xfer_n))) |-> $stable(code)); // R6

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (code == '0 && hi_q == '0 && lo_q == '0)); // R9

endmodule

bind dacbuf_core dacbuf_core_chk #(.BUS_W(BUS_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .wr1_n   (wr1_n),
    .wr2_n   (wr2_n),
    .xfer_n  (xfer_n),
    .byte_hi (byte_hi),
    .bus_in  (bus_in),
    .hi_q    (hi_q),
    .lo_q    (lo_q),
    .code    (code)
);

// File: tb/dacbuf_core_tb_top.sv
`timescale 1ns/1ps
module dacbuf_core_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, wr1_n = 1'b1, wr2_n = 1'b1, xfer_n = 1'b1, byte_hi = 1'b0;
    logic [7:0]  bus_in = '0;
    logic [15:0] code;

    int          n_vec = 0;
    int          n_bad = 0;
    bit          started = 1'b0;
    string       cur_req = "R9";
    int unsigned m_hi = 0, m_lo = 0, m_code = 0;
    int unsigned wd = 0;

    always #2.5 clk = ~clk;

    dacbuf_core dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr1_n(wr1_n), .wr2_n(wr2_n),
        .xfer_n(xfer_n), .byte_hi(byte_hi), .bus_in(bus_in), .code(code)
    );

    // Behavioural reference model, updated on each rising edge.
    always @(posedge clk) begin
        int unsigned nh, nl;
        started = 1'b1;
        if (!rst_n) begin
            m_hi = 0; m_lo = 0; m_code = 0;
        end else begin
            nh = m_hi; nl = m_lo;
            if (!cs_n && !wr1_n) begin
                nl = bus_in;
                if (byte_hi) nh = bus_in;
            end
            if (!wr2_n && !xfer_n) m_code = nh * 256 + nl;
            m_hi = nh; m_lo = nl;
        end
    end

    // Per-clock comparison against the model, away from the rising edge.
    always @(negedge clk) begin
        if (started) begin
            n_vec++;
            if (code !== m_code[15:0]) begin
                n_bad++;
                $display("FAIL %s model compare: actual %h expected %h", cur_req, code, m_code[15:0]);
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        wd++;
        if (wd > 100000) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    // Apply one clock of controls; returns on the next falling edge.
    task automatic apply(input logic cs, input logic w1, input logic bh,
                         input logic w2, input logic xf, input logic [7:0] d,
                         input string req);
        cur_req = req;
        cs_n = cs; wr1_n = w1; byte_hi = bh; wr2_n = w2; xfer_n = xf; bus_in = d;
        @(negedge clk);
    endtask

    // Auto-transfer wiring: xfer_n follows byte_hi, wr2_n follows wr1_n.
    task automatic apply_auto(input logic w1, input logic bh, input logic [7:0] d);
        apply(1'b0, w1, bh, w1, bh, d, "R8");
    endtask

    task automatic idle(input logic [7:0] d, input string req);
        apply(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, d, req);
    endtask

    task automatic xfer(input string req);
        apply(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, req);
    endtask

    task automatic chk(input string req, input logic [15:0] exp);
        n_vec++;
        if (code !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, code, exp);
        end
    endtask

    initial begin
        @(negedge clk);
        apply(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 8'h00, "R9");
        apply(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 8'h00, "R9");
        chk("R9 reset state", 16'h0000);
        rst_n = 1'b1;

        // R3 then R4: high write fills both, low write replaces low only.
        apply(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'hA5, "R3");
        chk("R6 staged high byte held off output", 16'h0000);
        xfer("R3");
        chk("R3 both latches take bus", 16'hA5A5);
        apply(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h3C, "R4");
        chk("R6 output holds during low write", 16'hA5A5);
        xfer("R1");
        chk("R1 byte mapping of assembled word", 16'hA53C);

        // R6: stage a new word while the old one is held.
        apply(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'h12, "R6");
        apply(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h34, "R6");
        idle(8'h99, "R6");
        chk("R6 old word held while new staged", 16'hA53C);
        apply(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'h00, "R6");
        chk("R6 wr2 alone does not transfer", 16'hA53C);
        apply(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, "R6");
        chk("R6 xfer alone does not transfer", 16'hA53C);
        xfer("R6");
        chk("R6 staged word transferred", 16'h1234);

        // R4: low-only write keeps high latch.
        apply(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'hFF, "R4");
        xfer("R4");
        chk("R4 high latch kept", 16'h12FF);

        // R2: strobe without chip select must be ignored.
        apply(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'h00, "R2");
        apply(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h5A, "R2");
        xfer("R2");
        chk("R2 write without chip select ignored", 16'h12FF);

        // R5: follow while enabled, hold once released.
        apply(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'h11, "R5");
        apply(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'h22, "R5");
        apply(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'h33, "R5");
        idle(8'hC3, "R5");
        idle(8'h0F, "R5");
        xfer("R5");
        chk("R5 latch followed then held", 16'h3333);

        // R7: write and transfer on the same clock.
        apply(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h77, "R7");
        chk("R7 fresh low byte reaches output", 16'h3377);
        apply(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h81, "R7");
        chk("R7 fresh both bytes reach output", 16'h8181);

        // R8: automatic transfer wiring.
        apply_auto(1'b0, 1'b1, 8'hBE);
        chk("R8 high write only stages", 16'h8181);
        apply_auto(1'b0, 1'b0, 8'hEF);
        chk("R8 low write transfers word", 16'hBEEF);
        apply_auto(1'b1, 1'b0, 8'h00);
        chk("R8 no strobe holds", 16'hBEEF);
        apply_auto(1'b0, 1'b1, 8'hFF);
        apply_auto(1'b0, 1'b0, 8'hFF);
        chk("R1 all-ones full scale", 16'hFFFF);
        apply_auto(1'b0, 1'b1, 8'h00);
        apply_auto(1'b0, 1'b0, 8'h00);
        chk("R1 all-zeros", 16'h0000);

        // R9: reset in mid sequence clears latches and output.
        apply_auto(1'b0, 1'b1, 8'h6D);
        apply_auto(1'b0, 1'b0, 8'h4B);
        chk("R8 before reset", 16'h6D4B);
        rst_n = 1'b0;
        idle(8'h00, "R9");
        chk("R9 output cleared", 16'h0000);
        rst_n = 1'b1;
        xfer("R9");
        chk("R9 latches cleared", 16'h0000);

        idle(8'h00, "R9");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule